// File: doc/BRIEF.md
# Timer Compare Channel with Interrupt Flags

This block is an 8-bit free-running timer slice. It has one compare channel and one overflow source. The counter runs in one of two modes:

- **Plain wrap mode:** the counter counts up and wraps to zero.
- **Phase-correct mode:** the counter counts up and down between zero and full scale, staying on each extreme value for exactly one cycle.

Each source has a sticky event flag and an enable bit. The flags and enables sit behind a small register bus, next to the compare value and a read-only view of the count. An interrupt request for a source is raised when three things are all one: the global interrupt enable input, that source's enable bit and that source's flag.

A flag can be cleared in two ways. Software can write a one to it. The interrupt controller can pulse the acknowledge line for that source when it takes the vector.

The register bus is a plain control port, not a data stream. A write completes in the cycle it is presented, with no stall and no handshake. Read data is a combinational function of the address. There is no back-pressure anywhere.

Top module: `tmr_cmp_irq`

## Requirements
- R1: While reset is asserted, the count is 0 and the compare (address 0), enable (address 1) and flag (address 2) registers all read 0x00.
- R2: In plain wrap mode (`mode_pc`=0) the count increments by one each cycle and wraps from 255 to 0. The overflow flag (bit 0) is set by the edge that wraps the count, so it reads 1 in the cycle where the count reads 0.
- R3: In phase-correct mode (`mode_pc`=1) the count rises to 255, then falls to 0, then rises again, holding each extreme for one cycle (254,255,254 and 1,0,1). The overflow flag is set only by the edge that leaves 0 after counting down, so it reads 1 when the count reads 1. It is not set at the top.
- R4: A cycle in which the count equals the compare register sets the compare flag (bit 1) at the next edge. A value written to address 0 is used for comparison from the cycle after the write.
- R5: Writing a one to a bit of the flag register clears that flag. Writing a zero leaves it unchanged.
- R6: A one-cycle pulse on `ack[i]` clears flag i (index 0 is overflow, index 1 is compare). It leaves the other flag unchanged.
- R7: When a set event and a clear (a write of one or an acknowledge) hit the same flag in the same cycle, the flag ends up as one.
- R8: `irq[i]` is high exactly when `gie`, enable bit i and flag i are all one. It follows those inputs with no added cycle.
- R9: In the enable and flag registers, bit 1 is the compare source and bit 0 is the overflow source. Bits 7:2 read as zero and ignore writes.
- R10: Address 3 returns the current count. Writes to it are ignored and do not disturb counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_pc | input | 1 | 0 = plain wrap counting, 1 = phase-correct up/down counting |
| gie | input | 1 | Global interrupt enable |
| bus_addr | input | 2 | Register address: 0 compare, 1 enable, 2 flags, 3 count |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ack | input | 2 | Vector-taken pulses: [1] compare, [0] overflow |
| irq | output | 2 | Interrupt requests: [1] compare, [0] overflow |
| count | output | 8 | Current counter value |

## Verification
The bench times each flag against the count output. It checks that the overflow flag in phase-correct mode appears after the bottom turnaround and not at the top. A design that flagged at the top, or that held the extremes for two cycles, would show the wrong count sequence or an early flag.

The bench also aims write-one and acknowledge clears at the exact cycle of a set event. A design that let the clear win would lose that event. A compare value written one cycle before a match must still fire the flag, which catches a design that delays or double-registers the compare value.

Write-zero, the reserved bits and writes to the count address are each checked for having no effect.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_W    = 8;
  localparam int TMR_NSRC = 2;
  localparam int SRC_OVF  = 0;
  localparam int SRC_CMP  = 1;

  typedef enum logic [1:0] {
    A_CMP  = 2'd0,
    A_MASK = 2'd1,
    A_FLAG = 2'd2,
    A_CNT  = 2'd3
  } tmr_addr_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = tmr_pkg::TMR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_pc,
  output logic [W-1:0] count,
  output logic         ovf_hit
);
  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] CNT_MIN = '0;
  localparam logic [W-1:0] ONE     = W'(1);

  logic         dir_dn;
  logic         at_top, at_bot;
  logic [W-1:0] cnt_nxt;
  logic         dir_nxt;

  always_comb begin
    at_top = (count == CNT_MAX);
    at_bot = (count == CNT_MIN);
    // overflow event: wrap in plain mode, bottom turnaround in phase-correct
    ovf_hit = mode_pc ? (at_bot && dir_dn) : at_top;
  end

  always_comb begin
    cnt_nxt = count + ONE;
    dir_nxt = 1'b0;
    if (mode_pc) begin
      if (!dir_dn) begin
        if (at_top) begin
          cnt_nxt = count - ONE;
          dir_nxt = 1'b1;
        end
      end else begin
        if (at_bot) begin
          cnt_nxt = count + ONE;
          dir_nxt = 1'b0;
        end else begin
          cnt_nxt = count - ONE;
          dir_nxt = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      dir_dn <= 1'b0;
    end else begin
      count  <= cnt_nxt;
      dir_dn <= dir_nxt;
    end
  end
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int N = tmr_pkg::TMR_NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr_wr,
  input  logic [N-1:0] clr_ack,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic nxt;
    // set has priority over any clear in the same cycle
    always_comb nxt = set_evt[i] | (flag_q[i] & ~(clr_wr[i] | clr_ack[i]));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= nxt;
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int W = tmr_pkg::TMR_W,
  parameter int N = tmr_pkg::TMR_NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  input  logic [W-1:0] count,
  input  logic [N-1:0] flag_q,
  output logic [W-1:0] cmp_val,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] flag_w1c,
  output logic [W-1:0] bus_rdata
);
  import tmr_pkg::*;
  localparam int PAD = W - N;

  logic wr_cmp, wr_mask, wr_flag;

  always_comb begin
    wr_cmp   = bus_wr && (bus_addr == A_CMP);
    wr_mask  = bus_wr && (bus_addr == A_MASK);
    wr_flag  = bus_wr && (bus_addr == A_FLAG);
    flag_w1c = wr_flag ? bus_wdata[N-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_val <= '0;
      mask_q  <= '0;
    end else begin
      if (wr_cmp)  cmp_val <= bus_wdata;
      if (wr_mask) mask_q  <= bus_wdata[N-1:0];
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_CMP:   bus_rdata = cmp_val;
      A_MASK:  bus_rdata = {{PAD{1'b0}}, mask_q};
      A_FLAG:  bus_rdata = {{PAD{1'b0}}, flag_q};
      default: bus_rdata = count;
    endcase
  end
endmodule

// File: rtl/tmr_cmp_irq.sv
module tmr_cmp_irq #(
  parameter int W = tmr_pkg::TMR_W,
  parameter int N = tmr_pkg::TMR_NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_pc,
  input  logic         gie,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [N-1:0] ack,
  output logic [N-1:0] irq,
  output logic [W-1:0] count
);
  import tmr_pkg::*;

  logic         ovf_hit;
  logic         cmp_hit;
  logic [W-1:0] cmp_val;
  logic [N-1:0] mask_q;
  logic [N-1:0] flag_q;
  logic [N-1:0] flag_w1c;
  logic [N-1:0] set_evt;

  tmr_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_pc (mode_pc),
    .count   (count),
    .ovf_hit (ovf_hit)
  );

  always_comb begin
    cmp_hit          = (count == cmp_val);
    set_evt          = '0;
    set_evt[SRC_OVF] = ovf_hit;
    set_evt[SRC_CMP] = cmp_hit;
  end

  tmr_regs #(.W(W), .N(N)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .count     (count),
    .flag_q    (flag_q),
    .cmp_val   (cmp_val),
    .mask_q    (mask_q),
    .flag_w1c  (flag_w1c),
    .bus_rdata (bus_rdata)
  );

  tmr_flags #(.N(N)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (set_evt),
    .clr_wr  (flag_w1c),
    .clr_ack (ack),
    .flag_q  (flag_q)
  );

  always_comb irq = {N{gie}} & mask_q & flag_q;
endmodule

// File: rtl/tmr_cmp_irq_chk.sv
module tmr_cmp_irq_chk #(
  parameter int W = tmr_pkg::TMR_W,
  parameter int N = tmr_pkg::TMR_NSRC
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode_pc,
  input logic         gie,
  input logic [1:0]   bus_addr,
  input logic         bus_wr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic [N-1:0] ack,
  input logic [N-1:0] irq,
  input logic [W-1:0] count,
  input logic         ovf_hit,
  input logic         cmp_hit,
  input logic [N-1:0] flag_q
);
  import tmr_pkg::*;
  localparam logic [W-1:0] CNT_MAX = '1;

  p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_pc |=> count == W'($past(count) + W'(1)));

  p_pc_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pc && count == CNT_MAX) |=> count == CNT_MAX - W'(1));

  p_cmp_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> flag_q[SRC_CMP]);

  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_FLAG && bus_wdata[SRC_CMP] && !cmp_hit) |=> !flag_q[SRC_CMP]);

  p_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[SRC_OVF] && !ovf_hit) |=> !flag_q[SRC_OVF]);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hit && (ack[SRC_OVF] || (bus_wr && bus_addr == A_FLAG))) |=> flag_q[SRC_OVF]);

  p_irq_gie_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> gie);

  p_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_MASK || bus_addr == A_FLAG) |-> bus_rdata[W-1:N] == '0);
endmodule

bind tmr_cmp_irq tmr_cmp_irq_chk #(.W(W), .N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_pc   (mode_pc),
  .gie       (gie),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .ack       (ack),
  .irq       (irq),
  .count     (count),
  .ovf_hit   (ovf_hit),
  .cmp_hit   (cmp_hit),
  .flag_q    (flag_q)
);

// File: tb/tb_tmr_cmp_irq.sv
`timescale 1ns/100ps
module tb_tmr_cmp_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_pc = 1'b0;
  logic       gie = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [1:0] ack = 2'b00;
  logic [1:0] irq;
  logic [7:0] count;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_cmp_irq dut (
    .clk(clk), .rst_n(rst_n), .mode_pc(mode_pc), .gie(gie),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ack(ack), .irq(irq), .count(count)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // advance one edge; inputs and samples sit 1 ns after the edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic wait_count(input logic [7:0] v);
    for (int i = 0; i < 600 && count != v; i++) step();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 count", count, 0);
    rd(2'd0, d); check("R1 compare", d, 0);
    rd(2'd1, d); check("R1 enable", d, 0);
    rd(2'd2, d); check("R1 flags", d, 0);
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    mode_pc = 1'b0;
    wait_count(8'd10);
    wr(2'd2, 8'h01);
    rd(2'd2, d); check("R2 ovf clear before wrap", d[0], 0);
    wait_count(8'd255);
    rd(2'd2, d); check("R2 ovf not set at 255", d[0], 0);
    step();
    check("R2 wrap to 0", count, 0);
    rd(2'd2, d); check("R2 ovf set on wrap", d[0], 1);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    wr(2'd2, 8'h00);
    rd(2'd2, d); check("R5 write zero keeps flag", d[0], 1);
    wr(2'd2, 8'h01);
    rd(2'd2, d); check("R5 write one clears flag", d[0], 0);
  endtask

  task automatic t_compare();
    logic [7:0] d;
    wait_count(8'd40);
    wr(2'd0, 8'd60);
    wr(2'd2, 8'h02);
    rd(2'd2, d); check("R4 cmp flag cleared", d[1], 0);
    wait_count(8'd49);
    wr(2'd0, 8'd50);
    check("R4 count at new value", count, 50);
    rd(2'd2, d); check("R4 no flag before match edge", d[1], 0);
    step();
    rd(2'd2, d); check("R4 flag after match", d[1], 1);
    rd(2'd0, d); check("R4 compare readback", d, 50);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    wait_count(8'd45);
    wr(2'd2, 8'h02);
    rd(2'd2, d); check("R7 pre-clear cmp", d[1], 0);
    wait_count(8'd50);
    wr(2'd2, 8'h02);
    rd(2'd2, d); check("R7 set beats write-one", d[1], 1);
    wait_count(8'd200);
    wr(2'd2, 8'h01);
    wait_count(8'd255);
    ack = 2'b01;
    step();
    ack = 2'b00;
    rd(2'd2, d); check("R7 set beats ack", d[0], 1);
  endtask

  task automatic t_ack();
    logic [7:0] d;
    step();
    ack = 2'b01; step(); ack = 2'b00;
    rd(2'd2, d); check("R6 ack0 clears ovf", d[0], 0);
    check("R6 ack0 leaves cmp", d[1], 1);
    ack = 2'b10; step(); ack = 2'b00;
    rd(2'd2, d); check("R6 ack1 clears cmp", d[1], 0);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    gie = 1'b0;
    wr(2'd0, 8'd128);
    wr(2'd1, 8'hFF);
    rd(2'd1, d); check("R9 enable upper bits zero", d, 8'h03);
    wr(2'd2, 8'hFC);
    rd(2'd2, d); check("R9 flag upper bits zero", d[7:2], 0);
    wait_count(8'd255);
    wr(2'd2, 8'h03);
    rd(2'd2, d); check("R9 ovf is bit 0", d[1:0], 2'b01);
    check("R8 no irq with gie low", irq, 0);
    gie = 1'b1;
    #0.5; check("R8 ovf irq", irq, 2'b01);
    wr(2'd1, 8'h02);
    check("R8 masked ovf", irq, 0);
    wait_count(8'd129);
    check("R8 cmp irq bit 1", irq, 2'b10);
    ack = 2'b10; step(); ack = 2'b00;
    check("R8 irq drops after ack", irq, 0);
    gie = 1'b0;
    wr(2'd1, 8'h00);
  endtask

  task automatic t_count_ro();
    logic [7:0] d;
    wait_count(8'd100);
    wr(2'd3, 8'h00);
    check("R10 count write ignored", count, 101);
    rd(2'd3, d); check("R10 count readback", d, 101);
  endtask

  task automatic t_pc();
    logic [7:0] d;
    wait_count(8'd100);
    mode_pc = 1'b1;
    wr(2'd2, 8'h01);
    wait_count(8'd254);
    step(); check("R3 reach top", count, 255);
    step(); check("R3 top held one cycle", count, 254);
    rd(2'd2, d); check("R3 no ovf at top", d[0], 0);
    wait_count(8'd1);
    step(); check("R3 reach bottom", count, 0);
    rd(2'd2, d); check("R3 no ovf yet at 0", d[0], 0);
    step(); check("R3 bottom held one cycle", count, 1);
    rd(2'd2, d); check("R3 ovf after turnaround", d[0], 1);
    mode_pc = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #10;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    step();
    t_wrap();
    t_w1c();
    t_compare();
    t_set_wins();
    t_ack();
    t_irq();
    t_count_ro();
    t_pc();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule